// File: doc/BRIEF.md
# Cell Framer with Command Insertion

This block turns whole 53-byte cells from an upstream cell buffer into one nibble stream with no gaps. Ahead of every cell it sends a two-nibble command byte made of an escape nibble and a second nibble. The second nibble is another escape when the downstream scrambler must restart its generator, and the value 4 when it must not. The block picks between the two by counting nibbles. The generator repeats every `GEN_PERIOD` nibbles, so a restart is only requested once that many nibbles have gone out since the last restart.

A one-cycle 8 kHz sync pulse causes a timing-marker command (escape, then 8) to be sent at the next octet boundary. This marker takes priority over cell data and over a new cell start. If the pulse arrives while a cell is being sent, the block finishes the current byte, inserts the marker and then carries on with the cell. Each output nibble carries tags, so the downstream stage can tell command nibbles, which it must not scramble, from data nibbles.

The upstream buffer raises `cell_avail` while it holds a complete cell that has not yet been started. The block acknowledges the start of a cell with `cell_start` and consumes one byte per `byte_rd`.

Top module: `cell_framer`

## Requirements
- R1: While reset is asserted, and until a cell or sync pulse arrives, `out_valid`, `byte_rd` and `cell_start` are low.
- R2: Every cell is sent as one start command byte (escape nibble, then a second command nibble), followed by `2*CELL_BYTES` data nibbles. Each byte is sent high half first, and `byte_rd` is high on the low-half cycle of each byte.
- R3: The first cell after reset uses the restart form of the start command: escape, then escape.
- R4: A start command uses the restart form only when at least `GEN_PERIOD` valid nibbles have been sent since the last nibble of the previous restart command. Otherwise it uses escape followed by nibble value 4.
- R5: A sync pulse that arrives while the output is idle puts the marker escape on the output in the next cycle, followed by nibble value 8.
- R6: A sync pulse that arrives during cell data lets the current byte finish, then inserts the marker. The cell then resumes with its next byte, and no byte is lost or repeated.
- R7: A sync pulse that arrives during a command byte is held until that byte has finished, and the marker follows it directly.
- R8: With no complete cell available and no marker pending, `out_valid` stays low and no filler is produced. A cell is only started while `cell_avail` is high.
- R9: When further cells are waiting, consecutive cells follow each other with no idle cycle in between.
- R10: `out_esc` is high only on escape nibbles, and `out_nib` is 0 on those nibbles. `out_cmd` is high on both nibbles of every command byte and low on data nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_avail | input | 1 | A complete, not yet started cell is waiting upstream |
| cell_byte | input | 8 | Current cell byte from upstream |
| sync_pulse | input | 1 | One-cycle 8 kHz timing pulse |
| cell_start | output | 1 | High on the escape nibble of a start command; upstream marks the cell as taken |
| byte_rd | output | 1 | Current byte consumed; upstream advances after this edge |
| out_valid | output | 1 | Output nibble is valid |
| out_nib | output | 4 | Output nibble |
| out_esc | output | 1 | Nibble is an escape symbol |
| out_cmd | output | 1 | Nibble belongs to a command byte and must not be scrambled |

## Verification
The sync pulse can coincide with three other activities: a cell start decision, the high or low half of a data byte, and the first nibble of a start command. Each case gets a directed task. That task drives the pulse at a negative edge on exactly the phase it targets, then checks the following nibbles one by one at the ports. A stream decoder runs alongside the tasks. It checks that every resumed cell continues with the correct next byte, and that every start command matches the restart rule, which it computes from its own nibble count.

// File: rtl/cell_framer.sv
module cell_framer #(
  parameter int CELL_BYTES = 53,
  parameter int GEN_PERIOD = 1023
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_avail,
  input  logic [7:0] cell_byte,
  input  logic       sync_pulse,
  output logic       cell_start,
  output logic       byte_rd,
  output logic       out_valid,
  output logic [3:0] out_nib,
  output logic       out_esc,
  output logic       out_cmd
);
  localparam int BW = $clog2(CELL_BYTES);
  localparam int GW = $clog2(GEN_PERIOD + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD_HI, S_CMD_LO, S_DATA_HI, S_DATA_LO} st_t;
  typedef enum logic [1:0] {K_SOC_RST, K_SOC, K_MARK} kind_t;

  st_t           st, st_nx;
  kind_t         kind, kind_nx;
  logic          in_cell, in_cell_nx;
  logic [BW-1:0] byte_cnt, byte_cnt_nx;
  logic [GW-1:0] gen_cnt, gen_nx;
  logic          sync_pend, sync_pend_nx;

  wire boundary  = (st == S_IDLE) || (st == S_CMD_LO) || (st == S_DATA_LO);
  wire sync_req  = sync_pulse | sync_pend;
  wire last_byte = byte_cnt == BW'(CELL_BYTES - 1);
  wire soc_end   = (st == S_CMD_LO) && (kind != K_MARK);

  assign out_valid  = st != S_IDLE;
  assign out_cmd    = (st == S_CMD_HI) || (st == S_CMD_LO);
  assign out_esc    = (st == S_CMD_HI) || (st == S_CMD_LO && kind == K_SOC_RST);
  assign cell_start = (st == S_CMD_HI) && (kind != K_MARK);
  assign byte_rd    = st == S_DATA_LO;

  always_comb begin
    case (st)
      S_DATA_HI: out_nib = cell_byte[7:4];
      S_DATA_LO: out_nib = cell_byte[3:0];
      S_CMD_LO:  out_nib = (kind == K_SOC) ? 4'd4 : (kind == K_MARK) ? 4'd8 : 4'd0;
      default:   out_nib = 4'd0;
    endcase
  end

  always_comb begin
    in_cell_nx  = in_cell;
    byte_cnt_nx = byte_cnt;
    if (soc_end) begin
      in_cell_nx  = 1'b1;
      byte_cnt_nx = '0;
    end else if (st == S_DATA_LO) begin
      byte_cnt_nx = byte_cnt + 1'b1;
      if (last_byte) in_cell_nx = 1'b0;
    end
  end

  always_comb begin
    if (st == S_CMD_LO && kind == K_SOC_RST) gen_nx = '0;
    else if (out_valid && gen_cnt != GW'(GEN_PERIOD)) gen_nx = gen_cnt + 1'b1;
    else gen_nx = gen_cnt;
  end

  always_comb begin
    st_nx        = st;
    kind_nx      = kind;
    sync_pend_nx = sync_pend | sync_pulse;
    if (st == S_CMD_HI) st_nx = S_CMD_LO;
    else if (st == S_DATA_HI) st_nx = S_DATA_LO;
    else if (boundary) begin
      if (sync_req) begin
        st_nx        = S_CMD_HI;
        kind_nx      = K_MARK;
        sync_pend_nx = 1'b0;
      end else if (in_cell_nx) begin
        st_nx = S_DATA_HI;
      end else if (cell_avail) begin
        st_nx   = S_CMD_HI;
        kind_nx = (gen_nx >= GW'(GEN_PERIOD)) ? K_SOC_RST : K_SOC;
      end else begin
        st_nx = S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind      <= K_SOC;
      in_cell   <= 1'b0;
      byte_cnt  <= '0;
      gen_cnt   <= GW'(GEN_PERIOD);
      sync_pend <= 1'b0;
    end else begin
      st        <= st_nx;
      kind      <= kind_nx;
      in_cell   <= in_cell_nx;
      byte_cnt  <= byte_cnt_nx;
      gen_cnt   <= gen_nx;
      sync_pend <= sync_pend_nx;
    end
  end

  assert_cmd_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmd && !out_esc) |-> $past(out_valid && out_cmd && out_esc));

  assert_rd_on_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rd |-> (out_valid && !out_cmd));

  assert_marker_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && !out_valid && !sync_pend) |=> (out_esc && out_cmd && !cell_start));

  assert_start_needs_cell_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start |-> cell_avail);

  assert_esc_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_esc |-> (out_cmd && out_valid && out_nib == 4'd0));
endmodule

// File: tb/cell_framer_bench.sv
module cell_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CELL_BYTES = 53;
  localparam int GEN_PERIOD = 1023;
  localparam int CELL_NIBS  = 2 * CELL_BYTES + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_r = 1'b0;
  int   pushed = 0, started = 0, rd_ptr = 0;
  int   checks = 0, errors = 0, cyc = 0;

  logic       cell_start, byte_rd, out_valid, out_esc, out_cmd;
  logic [3:0] out_nib;
  wire        cell_avail = pushed > started;
  wire  [7:0] cell_byte  = 8'(rd_ptr * 37 + 11);

  cell_framer #(.CELL_BYTES(CELL_BYTES), .GEN_PERIOD(GEN_PERIOD)) u_cell_framer (
    .clk(clk), .rst_n(rst_n), .cell_avail(cell_avail), .cell_byte(cell_byte),
    .sync_pulse(sync_r), .cell_start(cell_start), .byte_rd(byte_rd),
    .out_valid(out_valid), .out_nib(out_nib), .out_esc(out_esc), .out_cmd(out_cmd));

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cell_start) started <= started + 1;
    if (byte_rd) rd_ptr <= rd_ptr + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // stream decoder: independent model of the framing rules
  int  exp_idx = 0, bytes_in_cell = 0, since_xx = 0, hi_cnt = 0;
  bit  first = 1'b1, in_cell = 1'b0, half_lo = 1'b0, cmd_phase = 1'b0;
  int  xx_cnt = 0, x4_cnt = 0, mk_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!out_valid) begin
        if (in_cell) chk(1'b0, "R9 gap inside cell", 0, 1);
      end else if (!cmd_phase) begin
        if (out_esc && out_cmd) begin
          cmd_phase = 1'b1;
          hi_cnt = since_xx;
          if (half_lo) chk(1'b0, "R6 marker split a byte", 1, 0);
          since_xx++;
        end else if (out_cmd) begin
          chk(1'b0, "R2 command nibble without escape", int'(out_nib), 0);
          since_xx++;
        end else begin
          logic [7:0] eb;
          eb = 8'(exp_idx * 37 + 11);
          chk(in_cell, "R2 data outside cell", 1, 1);
          chk(out_nib == (half_lo ? eb[3:0] : eb[7:4]), "R6 data nibble",
              int'(out_nib), int'(half_lo ? eb[3:0] : eb[7:4]));
          chk(byte_rd == half_lo, "R2 byte_rd phase", int'(byte_rd), int'(half_lo));
          if (half_lo) begin
            exp_idx++;
            bytes_in_cell++;
            if (bytes_in_cell == CELL_BYTES) in_cell = 1'b0;
          end
          half_lo = !half_lo;
          since_xx++;
        end
      end else begin
        cmd_phase = 1'b0;
        chk(out_cmd, "R10 second command nibble tag", int'(out_cmd), 1);
        if (out_esc) begin
          chk(!in_cell, "R2 start inside cell", 1, 0);
          chk(first || hi_cnt >= GEN_PERIOD, "R4 restart start too early", hi_cnt, GEN_PERIOD);
          xx_cnt++; first = 1'b0; in_cell = 1'b1; bytes_in_cell = 0;
          since_xx = 0;
        end else if (out_nib == 4'd4) begin
          chk(!in_cell, "R2 start inside cell", 1, 0);
          chk(!(first || hi_cnt >= GEN_PERIOD), "R4 plain start where restart due", hi_cnt, GEN_PERIOD);
          x4_cnt++; in_cell = 1'b1; bytes_in_cell = 0;
          since_xx++;
        end else if (out_nib == 4'd8) begin
          mk_cnt++;
          since_xx++;
        end else begin
          chk(1'b0, "R10 unknown command nibble", int'(out_nib), 4);
          since_xx++;
        end
      end
    end
  end

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (!out_valid && pushed == started) quiet++; else quiet = 0;
    end
  endtask

  task automatic t_reset();
    chk(!out_valid && !byte_rd && !cell_start, "R1 outputs during reset",
        int'({out_valid, byte_rd, cell_start}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (10) begin
      @(negedge clk);
      chk(!out_valid && !cell_start, "R8 idle without cell", int'(out_valid), 0);
    end
  endtask

  task automatic t_first_cell();
    pushed++;
    @(negedge clk);
    chk(out_esc && out_cmd && cell_start, "R2 start escape", int'({out_esc, out_cmd}), 3);
    @(negedge clk);
    chk(out_esc && out_cmd, "R3 first start is restart form", int'(out_nib), 0);
    wait_idle();
    chk(xx_cnt == 1 && x4_cnt == 0, "R3 restart count", xx_cnt, 1);
    chk(rd_ptr == CELL_BYTES, "R2 bytes consumed", rd_ptr, CELL_BYTES);
  endtask

  task automatic t_back_to_back();
    int run = 0;
    int xx0 = xx_cnt, x40 = x4_cnt;
    pushed += 12;
    @(negedge clk);
    while (out_valid) begin run++; @(negedge clk); end
    chk(run == 12 * CELL_NIBS, "R9 contiguous cells", run, 12 * CELL_NIBS);
    wait_idle();
    chk(xx_cnt - xx0 == 1, "R4 one restart in run", xx_cnt - xx0, 1);
    chk(x4_cnt - x40 == 11, "R4 plain starts in run", x4_cnt - x40, 11);
  endtask

  task automatic t_sync_idle();
    sync_r = 1'b1;
    @(negedge clk); sync_r = 1'b0;
    chk(out_esc && out_cmd && !cell_start, "R5 marker escape next cycle", int'(out_esc), 1);
    @(negedge clk);
    chk(out_cmd && !out_esc && out_nib == 4'd8, "R5 marker value", int'(out_nib), 8);
    @(negedge clk);
    chk(!out_valid, "R8 idle after marker", int'(out_valid), 0);
  endtask

  task automatic t_sync_data();
    pushed++;
    @(negedge clk);
    while (!(out_valid && !out_cmd && !byte_rd)) @(negedge clk);
    sync_r = 1'b1;
    @(negedge clk); sync_r = 1'b0;
    chk(out_valid && !out_cmd && byte_rd, "R6 low half finishes first", int'(out_cmd), 0);
    @(negedge clk);
    chk(out_esc && out_cmd, "R6 marker escape after byte", int'(out_esc), 1);
    @(negedge clk);
    chk(out_cmd && out_nib == 4'd8, "R6 marker value", int'(out_nib), 8);
    @(negedge clk);
    chk(out_valid && !out_cmd && !byte_rd, "R6 cell resumes", int'(out_cmd), 0);
    repeat (6) @(negedge clk);
    while (!byte_rd) @(negedge clk);
    sync_r = 1'b1;
    @(negedge clk); sync_r = 1'b0;
    chk(out_esc && out_cmd, "R6 marker right after low half", int'(out_esc), 1);
    @(negedge clk);
    chk(out_cmd && out_nib == 4'd8, "R6 marker value low phase", int'(out_nib), 8);
    @(negedge clk);
    chk(out_valid && !out_cmd && !byte_rd, "R6 cell resumes after low phase", int'(out_cmd), 0);
    wait_idle();
  endtask

  task automatic t_sync_cmd();
    pushed++;
    @(negedge clk);
    chk(out_esc && out_cmd && cell_start, "R7 start escape", int'(out_esc), 1);
    sync_r = 1'b1;
    @(negedge clk); sync_r = 1'b0;
    chk(out_cmd && !(out_nib == 4'd8 && !out_esc), "R7 start byte completes", int'(out_nib), 4);
    @(negedge clk);
    chk(out_esc && out_cmd && !cell_start, "R7 held marker escape", int'(out_esc), 1);
    @(negedge clk);
    chk(out_cmd && out_nib == 4'd8, "R7 held marker value", int'(out_nib), 8);
    @(negedge clk);
    chk(out_valid && !out_cmd, "R7 data follows marker", int'(out_cmd), 0);
    wait_idle();
  endtask

  initial begin
    t_reset();
    t_first_cell();
    t_back_to_back();
    t_sync_idle();
    t_sync_data();
    t_sync_cmd();
    chk(mk_cnt == 4, "R5 marker total", mk_cnt, 4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "R1 watchdog expired", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule